// File: doc/BRIEF.md
# Low-Frequency Watchdog Timer with Selectable Timeout Tap

This block guards a device against software that has stopped making progress. It runs from a slow internal low-frequency clock. A fixed prescale counter divides that clock down to a base tick of about 4 ms. A postscaler then counts base ticks, and a select field chosen at run time decides how many ticks make up one timeout. The timeout is always a power of two of base ticks. If software does not issue a clear strobe before the timeout ends, the block raises a request.

The request depends on the power state. In normal run it is a device reset request. While the device is asleep it is a wake-up request instead. Several events restart the count from zero: a software clear, entry into sleep, a change of the oscillator frequency selection, a detected clock failure, and device reset. The timer counts while either the hardware configuration enable or the software enable is set. When both enables are low, the counters are held at zero.

Top module: `lfo_watchdog`

## Requirements
- R1: Device reset (`rst_n` low at a clock edge) drives both `rst_req` and `wake_req` low and clears both counters, so a run that begins after reset takes one full period to time out.
- R2: The timer counts only while `cfg_en` or `sw_en` is high; either one alone is enough. With both low, no request is raised and the counters stay at zero, so after re-enabling the timer a full period passes before the next request.
- R3: With the timer enabled, the first request appears `PRE_DIV * 2^sel` clock edges after counting begins, where `sel` is the unsigned tap select. A select above `POST_BITS-1` is treated as `POST_BITS-1`.
- R4: A request is high for exactly one clock cycle. After a request the counters restart from zero, so the next request follows one full period later.
- R5: Expiry while `in_sleep` is low raises `rst_req`. Expiry while `in_sleep` is high raises `wake_req`.
- R6: A `clr_strobe` pulse clears both counters, so the next request comes one full period after the clearing edge.
- R7: A `sleep_enter` pulse clears both counters in the same way as `clr_strobe`.
- R8: An `osc_sel_chg` pulse or a `clk_fail` pulse clears both counters in the same way as `clr_strobe`.
- R9: If any clear event is high at the same edge on which the timer would expire, no request is raised and the count restarts from zero.
- R10: `sel` is sampled on every base tick. If `sel` is lowered to a period that the tick count has already reached, the timer expires on the next base tick.
- R11: `rst_req` and `wake_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Low-frequency timer clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| cfg_en | input | 1 | Hardware configuration enable |
| sw_en | input | 1 | Software enable |
| clr_strobe | input | 1 | Clear-watchdog strobe, one cycle |
| sleep_enter | input | 1 | Strobe marking entry into sleep |
| osc_sel_chg | input | 1 | Strobe marking a change of oscillator frequency select |
| clk_fail | input | 1 | Clock-failure detected flag |
| in_sleep | input | 1 | High while the device is in a power-managed sleep mode |
| sel | input | SEL_W | Timeout tap select; period is 2^sel base ticks |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The bench builds the block with `PRE_DIV = 4` and `POST_BITS = 8`, which gives a 3-bit select. With these values a base tick lasts four cycles, and even the longest tap (128 ticks, 512 cycles) finishes in a short run. Every select value, including the largest one, can therefore be timed exactly. The short tick also lets the bench place a clear strobe on the exact expiry edge, and lower the select partway through a count, with cycle-level precision.

// File: rtl/wdt_pkg.sv
// Shared types for the low-frequency watchdog.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package wdt_pkg;

    // Sources that restart both watchdog counters.
    typedef struct packed {
        logic sw_clear;
        logic sleep_in;
        logic osc_change;
        logic clk_lost;
    } wdt_clr_src_t;

    // What the output stage raises on a given cycle.
    typedef enum logic [1:0] {
        FIRE_NONE  = 2'd0,
        FIRE_RESET = 2'd1,
        FIRE_WAKE  = 2'd2
    } wdt_fire_t;

    // Reduce all clear sources to one restart signal.
    function automatic logic clr_any(input wdt_clr_src_t s);
        return s.sw_clear | s.sleep_in | s.osc_change | s.clk_lost;
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
// Base-period divider: emits one tick every PRE_DIV clocks while running.
// Assumes: PRE_DIV >= 2; clear and !run both force the count back to zero.
module wdt_prescale #(
    parameter int PRE_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = $clog2(PRE_DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRE_DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Tick on the last count of each base period, never on a cleared cycle.
    always_comb tick = run && !clear && (cnt == LAST);

    // Advance the divider, wrapping at the end of the base period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clear) cnt <= '0;
        else if (cnt == LAST)        cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    // R3: the divider never leaves its range.
    a_r3_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < PRE_DIV);

    // R6: a clear leaves the divider at zero.
    a_r6_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt == '0);

endmodule

// File: rtl/wdt_postscale.sv
// Postscaler: counts base ticks and flags expiry at the selected power-of-two tap.
// Assumes: sel is sampled every tick; a select beyond the top tap is clamped.
module wdt_postscale #(
    parameter int POST_BITS = 16,
    parameter int SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int TOP = POST_BITS - 1;

    logic [POST_BITS-1:0] cnt;
    logic [POST_BITS:0]   nxt;
    logic [POST_BITS-1:0] reach;
    logic [SEL_W-1:0]     eff_sel;

    // Tick count including the tick in progress.
    always_comb nxt = {1'b0, cnt} + 1'b1;

    // Tap k is reached once the count including this tick is at least 2^k.
    for (genvar k = 0; k < POST_BITS; k++) begin : g_tap
        always_comb reach[k] = |nxt[POST_BITS:k];
    end

    // Clamp the select to the top tap.
    always_comb eff_sel = (32'(sel) > TOP) ? SEL_W'(TOP) : sel;

    // Expire on a tick whose count reaches the selected tap.
    always_comb expire = tick && reach[eff_sel];

    // Count ticks; restart after expiry, on clear or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clear) cnt <= '0;
        else if (expire)             cnt <= '0;
        else if (tick)               cnt <= nxt[POST_BITS-1:0];
    end

    // R6: a clear leaves the postscaler at zero.
    a_r6_post_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt == '0);

    // R4: the postscaler restarts after an expiry.
    a_r4_post_restart: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt == '0);

endmodule

// File: rtl/wdt_route.sv
// Output stage: turns an expiry into a one-cycle reset or wake-up request.
// Assumes: in_sleep is stable around expiry; outputs are registered.
module wdt_route
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic in_sleep,
    output logic rst_req,
    output logic wake_req
);
    wdt_fire_t fire_d, fire_q;

    // Choose the request kind from the power state.
    always_comb begin
        if (!expire)      fire_d = FIRE_NONE;
        else if (in_sleep) fire_d = FIRE_WAKE;
        else              fire_d = FIRE_RESET;
    end

    // Register the request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= FIRE_NONE;
        else        fire_q <= fire_d;
    end

    // Decode the registered request onto the pins.
    always_comb begin
        rst_req  = (fire_q == FIRE_RESET);
        wake_req = (fire_q == FIRE_WAKE);
    end

    // R5: a wake-up request only follows an expiry seen while asleep.
    a_r5_wake_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(in_sleep));

    // R5: a reset request only follows an expiry seen while running.
    a_r5_reset_awake: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(in_sleep));

endmodule

// File: rtl/lfo_watchdog.sv
// Watchdog timer: prescaler, selectable postscaler tap and reset/wake routing.
// Assumes: all inputs are synchronous to clk_lf; clear strobes last one cycle.
module lfo_watchdog
    import wdt_pkg::*;
#(
    parameter int PRE_DIV   = 128,
    parameter int POST_BITS = 16,
    parameter int SEL_W     = $clog2(POST_BITS)
) (
    input  logic             clk_lf,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             sw_en,
    input  logic             clr_strobe,
    input  logic             sleep_enter,
    input  logic             osc_sel_chg,
    input  logic             clk_fail,
    input  logic             in_sleep,
    input  logic [SEL_W-1:0] sel,
    output logic             rst_req,
    output logic             wake_req
);
    wdt_clr_src_t clr_src;
    logic         clear;
    logic         run;
    logic         tick;
    logic         expire;

    // Gather the clear sources and the enable.
    always_comb begin
        clr_src.sw_clear   = clr_strobe;
        clr_src.sleep_in   = sleep_enter;
        clr_src.osc_change = osc_sel_chg;
        clr_src.clk_lost   = clk_fail;
        clear              = clr_any(clr_src);
        run                = cfg_en | sw_en;
    end

    wdt_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk   (clk_lf),
        .rst_n (rst_n),
        .run   (run),
        .clear (clear),
        .tick  (tick)
    );

    wdt_postscale #(.POST_BITS(POST_BITS), .SEL_W(SEL_W)) u_post (
        .clk    (clk_lf),
        .rst_n  (rst_n),
        .run    (run),
        .clear  (clear),
        .tick   (tick),
        .sel    (sel),
        .expire (expire)
    );

    wdt_route u_route (
        .clk      (clk_lf),
        .rst_n    (rst_n),
        .expire   (expire),
        .in_sleep (in_sleep),
        .rst_req  (rst_req),
        .wake_req (wake_req)
    );

    // R11: the two requests are mutually exclusive.
    a_r11_exclusive: assert property (@(posedge clk_lf) disable iff (!rst_n)
        !(rst_req && wake_req));

    // R4: a reset request lasts one cycle.
    a_r4_one_cycle_rst: assert property (@(posedge clk_lf) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4: a wake-up request lasts one cycle.
    a_r4_one_cycle_wake: assert property (@(posedge clk_lf) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R9: a clear event suppresses any request at that edge.
    a_r9_clear_wins: assert property (@(posedge clk_lf) disable iff (!rst_n)
        clear |=> !(rst_req || wake_req));

    // R2: no request follows a cycle with both enables low.
    a_r2_idle_quiet: assert property (@(posedge clk_lf) disable iff (!rst_n)
        !run |=> !(rst_req || wake_req));

endmodule

// File: tb/sim_lfo_watchdog.sv
module sim_lfo_watchdog;
    localparam int PD = 4;
    localparam int PB = 8;
    localparam int SW = 3;
    localparam int NV = 6;
    localparam int V_SEL [NV] = '{0, 1, 3, 7, 2, 5};
    localparam bit V_SLP [NV] = '{0, 1, 0, 1, 1, 0};

    logic clk = 0;
    logic rst_n, cfg_en, sw_en, clr_strobe, sleep_enter, osc_sel_chg, clk_fail, in_sleep;
    logic [SW-1:0] sel;
    logic rst_req, wake_req;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    lfo_watchdog #(.PRE_DIV(PD), .POST_BITS(PB)) u0 (
        .clk_lf(clk), .rst_n(rst_n), .cfg_en(cfg_en), .sw_en(sw_en),
        .clr_strobe(clr_strobe), .sleep_enter(sleep_enter), .osc_sel_chg(osc_sel_chg),
        .clk_fail(clk_fail), .in_sleep(in_sleep), .sel(sel),
        .rst_req(rst_req), .wake_req(wake_req));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count edges until the first request; also watch R11 on every sample.
    task automatic measure(input int limit, output int cyc, output bit r, output bit w);
        cyc = 0; r = 0; w = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); @(negedge clk);
            if (rst_req && wake_req) check(0, "R11", 1, 0);
            if (rst_req || wake_req) begin
                cyc = i; r = rst_req; w = wake_req;
                break;
            end
        end
    endtask

    task automatic stop_all();
        cfg_en = 0; sw_en = 0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    // One-cycle strobe that lands on the next edge.
    task automatic pulse(input int which);
        case (which)
            0: clr_strobe = 1;
            1: sleep_enter = 1;
            2: osc_sel_chg = 1;
            default: clk_fail = 1;
        endcase
        @(posedge clk); @(negedge clk);
        clr_strobe = 0; sleep_enter = 0; osc_sel_chg = 0; clk_fail = 0;
    endtask

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c; bit r, w;
        rst_n = 0; cfg_en = 0; sw_en = 0; clr_strobe = 0; sleep_enter = 0;
        osc_sel_chg = 0; clk_fail = 0; in_sleep = 0; sel = '0;
        edges(3);
        // R1: reset state
        check(!rst_req && !wake_req, "R1 outputs low in reset", int'(rst_req | wake_req), 0);
        rst_n = 1;
        edges(1);
        check(!rst_req && !wake_req, "R1 outputs low after reset", int'(rst_req | wake_req), 0);

        // Table walk: R3 period and R5 routing per select/sleep pair
        for (int v = 0; v < NV; v++) begin
            stop_all();
            sel = SW'(V_SEL[v]); in_sleep = V_SLP[v]; cfg_en = 1;
            measure(2000, c, r, w);
            check(c == (PD << V_SEL[v]), "R3 period", c, PD << V_SEL[v]);
            check(r == !V_SLP[v] && w == V_SLP[v], "R5 routing", {r, w}, {!V_SLP[v], V_SLP[v]});
        end
        in_sleep = 0;

        // R4: single-cycle pulse and restart
        stop_all(); sel = 2; cfg_en = 1;
        measure(200, c, r, w);
        edges(1);
        check(!rst_req, "R4 pulse one cycle", int'(rst_req), 0);
        measure(200, c, r, w);
        check(c == 4 * PD - 1, "R4 next period", c, 4 * PD - 1);

        // R2: disabled stays quiet; sw_en alone runs; re-enable counts from zero
        stop_all();
        measure(20 * PD, c, r, w);
        check(c == 0, "R2 disabled no request", c, 0);
        sw_en = 1;
        measure(200, c, r, w);
        check(c == 4 * PD, "R2 sw_en alone", c, 4 * PD);
        stop_all(); cfg_en = 1;
        edges(10);
        stop_all(); cfg_en = 1;
        measure(200, c, r, w);
        check(c == 4 * PD, "R2 restart from zero", c, 4 * PD);

        // R6/R7/R8: each clear source restarts the count
        for (int s = 0; s < 4; s++) begin
            stop_all(); cfg_en = 1;
            edges(10);
            pulse(s);
            measure(200, c, r, w);
            check(c == 4 * PD, (s == 0) ? "R6 clr_strobe" : (s == 1) ? "R7 sleep_enter" :
                  (s == 2) ? "R8 osc_sel_chg" : "R8 clk_fail", c, 4 * PD);
        end

        // R9: clear on the expiry edge suppresses the request
        stop_all(); sel = 1; cfg_en = 1;
        edges(2 * PD - 1);
        clr_strobe = 1;
        @(posedge clk); @(negedge clk);
        clr_strobe = 0;
        check(!rst_req && !wake_req, "R9 suppressed", int'(rst_req | wake_req), 0);
        measure(200, c, r, w);
        check(c == 2 * PD, "R9 restart after clash", c, 2 * PD);

        // R10: lowering the select past the reached count expires next tick
        stop_all(); sel = 3; cfg_en = 1;
        edges(3 * PD);
        sel = 1;
        measure(200, c, r, w);
        check(c == PD, "R10 lowered tap", c, PD);

        // R1: mid-count reset clears the counters
        stop_all(); sel = 2; cfg_en = 1;
        edges(10);
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        check(!rst_req && !wake_req, "R1 reset mid-count", int'(rst_req | wake_req), 0);
        rst_n = 1;
        measure(200, c, r, w);
        check(c == 4 * PD, "R1 full period after reset", c, 4 * PD);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule